// File: doc/BRIEF.md
# Microinstruction Privilege Access Checker

This block sits between the control-store read port and the datapath. Every microinstruction word has an access lock with two parts: a minimum privilege level and a mask of the sensitive capabilities it needs. In the same cycle, the block compares that lock with the requester's current privilege level and with the capabilities granted to the requester. A word that passes issues its control bits unchanged. A word that fails is stopped: its control bits are forced to zero, a fault pulse is raised, and the reason for the fault is reported.

The check runs on every microinstruction, not once per page or per macro-instruction. The decision path has no registers. The only clocked state is a fault-capture register. It keeps the microaddress, the required privilege, the required mask and the cause of the first failing word, and it holds them until software clears it.

Top module: `uacc_access_gate`

## Requirements
- R1: Privilege levels are unsigned numbers from 0 (user) to 3 (hypervisor). The privilege part of the check passes only when the required level is less than or equal to `cur_priv_i`.
- R2: The capability part of the check passes only when every bit that is set in `req_cap_i` is also set in `grant_cap_i`. Extra granted bits have no effect.
- R3: `issue_o` is high exactly when `valid_i` is high and both parts of the check pass. In that case `ctrl_o` equals `ctrl_i`. In every other case `ctrl_o` is all zeros.
- R4: `fault_o` is high exactly in the cycles where `valid_i` is high and at least one part of the check fails. `fault_o` and `issue_o` are never high together.
- R5: `fault_cause_o` bit 0 is set when the privilege is too low, and bit 1 is set when a required capability is missing. Both bits can be set together. `fault_cause_o` is zero when `fault_o` is low.
- R6: When a fault occurs while the capture register is empty, the next rising clock edge sets `cap_valid_o`. The same edge loads the microaddress, the required privilege, the required mask and the cause.
- R7: While the capture register holds a fault and no clear is requested, later faults leave its contents unchanged.
- R8: `clear_fault_i` empties the capture register at the next edge and zeroes its fields. If a fault occurs in the same cycle as the clear, that new fault is captured instead.
- R9: After reset, `cap_valid_o` is low and every capture field is zero.
- R10: When `valid_i` is low, `issue_o` and `fault_o` stay low and the capture register does not change, whatever the lock fields contain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A microinstruction is presented this cycle |
| uaddr_i | input | ADDR_W | Microaddress of the presented word |
| req_priv_i | input | PRIV_W | Minimum privilege required by the word |
| req_cap_i | input | CAP_W | Capabilities required by the word |
| ctrl_i | input | CTRL_W | Control bits of the word |
| cur_priv_i | input | PRIV_W | Current privilege level of the requester |
| grant_cap_i | input | CAP_W | Capabilities granted to the requester |
| clear_fault_i | input | 1 | Empties the capture register |
| issue_o | output | 1 | The word is allowed to take effect |
| ctrl_o | output | CTRL_W | Control bits after gating |
| fault_o | output | 1 | Access fault in this cycle |
| fault_cause_o | output | 2 | Cause of the fault: bit0 privilege, bit1 capability |
| cap_valid_o | output | 1 | The capture register holds a fault |
| cap_uaddr_o | output | ADDR_W | Captured microaddress |
| cap_priv_o | output | PRIV_W | Captured required privilege |
| cap_mask_o | output | CAP_W | Captured required mask |
| cap_cause_o | output | 2 | Captured fault cause |

## Verification
The properties assume that the lock fields, the privilege inputs and the control inputs are stable and known during the cycle in which they are sampled. They also assume that `clear_fault_i` is a level sampled at the clock edge. The bench drives every input on the falling edge and does not change it again until the next falling edge. Random values cover the full range of every field, with `valid_i` and `clear_fault_i` drawn at fixed rates. Directed cases pin down the boundaries: equal privilege levels, all capability bits required, a fault that arrives at the same time as a clear, and a word that would fail but is not valid.

// File: rtl/uacc_pkg.sv
package uacc_pkg;
  localparam int CAUSE_W = 2;
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PRIV = 2'b01,
    CAUSE_CAP  = 2'b10,
    CAUSE_BOTH = 2'b11
  } fault_cause_e;
endpackage

// File: rtl/uacc_priv_cmp.sv
module uacc_priv_cmp #(
  parameter int PRIV_W = 2
) (
  input  logic [PRIV_W-1:0] req_priv_i,
  input  logic [PRIV_W-1:0] cur_priv_i,
  output logic              ok_o
);
  assign ok_o = (req_priv_i <= cur_priv_i);
endmodule

// File: rtl/uacc_cap_cmp.sv
module uacc_cap_cmp #(
  parameter int CAP_W = 6
) (
  input  logic [CAP_W-1:0] req_cap_i,
  input  logic [CAP_W-1:0] grant_cap_i,
  output logic [CAP_W-1:0] missing_o,
  output logic             ok_o
);
  for (genvar i = 0; i < CAP_W; i++) begin : g_bit
    assign missing_o[i] = req_cap_i[i] & ~grant_cap_i[i];
  end
  assign ok_o = ~|missing_o;
endmodule

// File: rtl/uacc_fault_capture.sv
module uacc_fault_capture #(
  parameter int ADDR_W = 10,
  parameter int PRIV_W = 2,
  parameter int CAP_W  = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            fault_i,
  input  logic                            clear_i,
  input  logic [ADDR_W-1:0]               uaddr_i,
  input  logic [PRIV_W-1:0]               priv_i,
  input  logic [CAP_W-1:0]                mask_i,
  input  uacc_pkg::fault_cause_e          cause_i,
  output logic                            held_o,
  output logic [ADDR_W-1:0]               uaddr_o,
  output logic [PRIV_W-1:0]               priv_o,
  output logic [CAP_W-1:0]                mask_o,
  output uacc_pkg::fault_cause_e          cause_o
);
  logic load;
  // first fault wins; clear reopens the slot in the same cycle
  assign load = fault_i & (~held_o | clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o  <= 1'b0;
      uaddr_o <= '0;
      priv_o  <= '0;
      mask_o  <= '0;
      cause_o <= uacc_pkg::CAUSE_NONE;
    end else if (load) begin
      held_o  <= 1'b1;
      uaddr_o <= uaddr_i;
      priv_o  <= priv_i;
      mask_o  <= mask_i;
      cause_o <= cause_i;
    end else if (clear_i) begin
      held_o  <= 1'b0;
      uaddr_o <= '0;
      priv_o  <= '0;
      mask_o  <= '0;
      cause_o <= uacc_pkg::CAUSE_NONE;
    end
  end
endmodule

// File: rtl/uacc_access_gate.sv
module uacc_access_gate #(
  parameter int ADDR_W = 10,
  parameter int PRIV_W = 2,
  parameter int CAP_W  = 6,
  parameter int CTRL_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] uaddr_i,
  input  logic [PRIV_W-1:0] req_priv_i,
  input  logic [CAP_W-1:0]  req_cap_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [PRIV_W-1:0] cur_priv_i,
  input  logic [CAP_W-1:0]  grant_cap_i,
  input  logic              clear_fault_i,
  output logic              issue_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              fault_o,
  output logic [1:0]        fault_cause_o,
  output logic              cap_valid_o,
  output logic [ADDR_W-1:0] cap_uaddr_o,
  output logic [PRIV_W-1:0] cap_priv_o,
  output logic [CAP_W-1:0]  cap_mask_o,
  output logic [1:0]        cap_cause_o
);
  import uacc_pkg::*;

  logic             priv_ok, cap_ok, pass;
  logic [CAP_W-1:0] cap_missing;
  fault_cause_e     cause, cap_cause;

  uacc_priv_cmp #(.PRIV_W(PRIV_W)) u_priv (
    .req_priv_i(req_priv_i),
    .cur_priv_i(cur_priv_i),
    .ok_o      (priv_ok)
  );

  uacc_cap_cmp #(.CAP_W(CAP_W)) u_cap (
    .req_cap_i  (req_cap_i),
    .grant_cap_i(grant_cap_i),
    .missing_o  (cap_missing),
    .ok_o       (cap_ok)
  );

  assign pass    = priv_ok & cap_ok;
  assign issue_o = valid_i & pass;
  assign fault_o = valid_i & ~pass;
  assign ctrl_o  = issue_o ? ctrl_i : '0;

  always_comb begin
    cause = CAUSE_NONE;
    if (fault_o) cause = fault_cause_e'({~cap_ok, ~priv_ok});
  end
  assign fault_cause_o = cause;

  uacc_fault_capture #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .CAP_W(CAP_W)) u_capt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_o),
    .clear_i(clear_fault_i),
    .uaddr_i(uaddr_i),
    .priv_i (req_priv_i),
    .mask_i (req_cap_i),
    .cause_i(cause),
    .held_o (cap_valid_o),
    .uaddr_o(cap_uaddr_o),
    .priv_o (cap_priv_o),
    .mask_o (cap_mask_o),
    .cause_o(cap_cause)
  );
  assign cap_cause_o = cap_cause;

  logic unused_missing;
  assign unused_missing = ^cap_missing;
endmodule

// File: rtl/uacc_access_gate_chk.sv
module uacc_access_gate_chk #(
  parameter int ADDR_W = 10,
  parameter int PRIV_W = 2,
  parameter int CAP_W  = 6,
  parameter int CTRL_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ADDR_W-1:0] uaddr_i,
  input logic [PRIV_W-1:0] req_priv_i,
  input logic [CAP_W-1:0]  req_cap_i,
  input logic [PRIV_W-1:0] cur_priv_i,
  input logic [CAP_W-1:0]  grant_cap_i,
  input logic              clear_fault_i,
  input logic              issue_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              fault_o,
  input logic [1:0]        fault_cause_o,
  input logic              cap_valid_o,
  input logic [ADDR_W-1:0] cap_uaddr_o
);
  a_r1_issue_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (req_priv_i <= cur_priv_i));
  a_r2_issue_caps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ((req_cap_i & ~grant_cap_i) == '0));
  a_r3_ctrl_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |-> (ctrl_o == '0));
  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && fault_o));
  a_r5_cause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (fault_cause_o == 2'b00));
  a_r6_capture_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && (!cap_valid_o || clear_fault_i)) |=>
      (cap_valid_o && cap_uaddr_o == $past(uaddr_i)));
  a_r7_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_o && !clear_fault_i) |=> (cap_valid_o && $stable(cap_uaddr_o)));
  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_fault_i && !fault_o) |=> !cap_valid_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!issue_o && !fault_o));
endmodule

bind uacc_access_gate uacc_access_gate_chk #(
  .ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .CAP_W(CAP_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .uaddr_i(uaddr_i),
  .req_priv_i(req_priv_i), .req_cap_i(req_cap_i), .cur_priv_i(cur_priv_i),
  .grant_cap_i(grant_cap_i), .clear_fault_i(clear_fault_i), .issue_o(issue_o),
  .ctrl_o(ctrl_o), .fault_o(fault_o), .fault_cause_o(fault_cause_o),
  .cap_valid_o(cap_valid_o), .cap_uaddr_o(cap_uaddr_o)
);

// File: tb/uacc_access_gate_tb.sv
`timescale 1ns/1ps
module uacc_access_gate_tb;
  localparam int ADDR_W = 10, PRIV_W = 2, CAP_W = 6, CTRL_W = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid, clr;
  logic [ADDR_W-1:0] uaddr;
  logic [PRIV_W-1:0] rpriv, cpriv;
  logic [CAP_W-1:0]  rcap, gcap;
  logic [CTRL_W-1:0] ctrl;
  logic issue, fault, cap_v;
  logic [CTRL_W-1:0] ctrl_out;
  logic [1:0] cause, cap_cause;
  logic [ADDR_W-1:0] cap_addr;
  logic [PRIV_W-1:0] cap_priv;
  logic [CAP_W-1:0]  cap_mask;

  int checks = 0, failures = 0;
  bit e_held;
  logic [ADDR_W-1:0] e_addr;
  logic [PRIV_W-1:0] e_priv;
  logic [CAP_W-1:0]  e_mask;
  logic [1:0]        e_cause;

  always #2 clk = ~clk;

  uacc_access_gate #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .CAP_W(CAP_W), .CTRL_W(CTRL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .uaddr_i(uaddr),
    .req_priv_i(rpriv), .req_cap_i(rcap), .ctrl_i(ctrl), .cur_priv_i(cpriv),
    .grant_cap_i(gcap), .clear_fault_i(clr), .issue_o(issue), .ctrl_o(ctrl_out),
    .fault_o(fault), .fault_cause_o(cause), .cap_valid_o(cap_v),
    .cap_uaddr_o(cap_addr), .cap_priv_o(cap_priv), .cap_mask_o(cap_mask),
    .cap_cause_o(cap_cause)
  );

  function automatic logic [1:0] exp_cause(logic [PRIV_W-1:0] rp, logic [PRIV_W-1:0] cp,
                                           logic [CAP_W-1:0] rc, logic [CAP_W-1:0] gc);
    logic [1:0] c;
    c[0] = (rp > cp);
    for (int i = 0; i < CAP_W; i++) if (rc[i] && !gc[i]) c[1] = 1'b1;
    if (!(|(rc & ~gc))) c[1] = 1'b0;
    return c;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check_capture(string req);
    check(req, "cap_valid", 64'(cap_v), 64'(e_held));
    check(req, "cap_uaddr", 64'(cap_addr), 64'(e_addr));
    check(req, "cap_priv", 64'(cap_priv), 64'(e_priv));
    check(req, "cap_mask", 64'(cap_mask), 64'(e_mask));
    check(req, "cap_cause", 64'(cap_cause), 64'(e_cause));
  endtask

  // one cycle: check capture from last edge, drive, check comb, advance model
  task automatic cyc(string req, bit v, logic [ADDR_W-1:0] a, logic [PRIV_W-1:0] rp,
                     logic [CAP_W-1:0] rc, logic [CTRL_W-1:0] c, logic [PRIV_W-1:0] cp,
                     logic [CAP_W-1:0] gc, bit cl);
    logic [1:0] ec;
    bit ef, ei;
    @(negedge clk);
    check_capture(req);
    valid = v; uaddr = a; rpriv = rp; rcap = rc; ctrl = c; cpriv = cp; gcap = gc; clr = cl;
    #1;
    ec = exp_cause(rp, cp, rc, gc);
    ei = v && (ec == 2'b00);
    ef = v && (ec != 2'b00);
    check(req, "issue", 64'(issue), 64'(ei));
    check(req, "ctrl", 64'(ctrl_out), ei ? 64'(c) : 64'd0);
    check(req, "fault", 64'(fault), 64'(ef));
    check(req, "fault_cause", 64'(cause), ef ? 64'(ec) : 64'd0);
    if (ef && (!e_held || cl)) begin
      e_held = 1; e_addr = a; e_priv = rp; e_mask = rc; e_cause = ec;
    end else if (cl) begin
      e_held = 0; e_addr = '0; e_priv = '0; e_mask = '0; e_cause = '0;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    valid = 0; clr = 0; uaddr = '0; rpriv = '0; rcap = '0; ctrl = '0; cpriv = '0; gcap = '0;
    e_held = 0; e_addr = '0; e_priv = '0; e_mask = '0; e_cause = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R9 reset state observed in the first cycle's capture check
    cyc("R9", 0, 10'h000, 2'd0, 6'h00, 32'h0, 2'd0, 6'h00, 0);
    // R1 equal privilege passes, R3 control passes through
    cyc("R1", 1, 10'h011, 2'd2, 6'h00, 32'hCAFE_0001, 2'd2, 6'h00, 0);
    // R2 all caps required and granted
    cyc("R2", 1, 10'h012, 2'd0, 6'h3F, 32'hCAFE_0002, 2'd0, 6'h3F, 0);
    // R2 extra grants harmless
    cyc("R2", 1, 10'h013, 2'd1, 6'h04, 32'hCAFE_0003, 2'd3, 6'h3F, 0);
    // R10 failing lock but not valid
    cyc("R10", 0, 10'h014, 2'd3, 6'h3F, 32'hFFFF_FFFF, 2'd0, 6'h00, 0);
    // R1/R5 privilege shortfall by one, first fault captured (R6)
    cyc("R5", 1, 10'h101, 2'd3, 6'h00, 32'h1234_5678, 2'd2, 6'h3F, 0);
    // R7 second fault (capability) ignored while held
    cyc("R7", 1, 10'h202, 2'd0, 6'h20, 32'h1111_1111, 2'd3, 6'h1F, 0);
    // R8 clear with no fault
    cyc("R7", 0, 10'h000, 2'd0, 6'h00, 32'h0, 2'd0, 6'h00, 1);
    // R5 both causes, captured into empty register (R6)
    cyc("R8", 1, 10'h303, 2'd1, 6'h01, 32'h2222_2222, 2'd0, 6'h00, 0);
    // R8 clear coincides with new fault: new fault wins
    cyc("R6", 1, 10'h3FF, 2'd3, 6'h02, 32'h3333_3333, 2'd1, 6'h02, 1);
    cyc("R8", 0, 10'h000, 2'd0, 6'h00, 32'h0, 2'd0, 6'h00, 1);
    cyc("R8", 0, 10'h000, 2'd0, 6'h00, 32'h0, 2'd0, 6'h00, 0);
    // R3 random mix
    for (int n = 0; n < 3000; n++) begin
      cyc("R3", ($urandom % 4) != 0, ADDR_W'($urandom), PRIV_W'($urandom), CAP_W'($urandom),
          $urandom, PRIV_W'($urandom), CAP_W'($urandom | $urandom), ($urandom % 20) == 0);
    end
    cyc("R6", 0, 10'h000, 2'd0, 6'h00, 32'h0, 2'd0, 6'h00, 0);
    finish_run();
  end
endmodule